// File: doc/BRIEF.md
# Stack Push/Pop/Call/Return Unit

This block carries out the four stack instructions of a 64-bit processor: push a register, pop into a register, call a subroutine and return from one. The surrounding pipeline hands it the current stack pointer, the register value to store, the address of the next instruction, the call target, the instruction's own address and the destination register number, and then pulses `start`. The unit makes exactly one 8-byte access to data memory. It then presents the final stack pointer, the popped value with its destination, the next program counter and a status code during a single-cycle `done` pulse.

The stack grows downward. A push or a call steps the stack pointer down by one word before it stores. A pop or a return loads at the current pointer and then steps it up. The unit checks every address against the memory size itself. An address outside the memory causes no access at all. The instruction then ends with an address-error status, and the stack pointer is restored to its value from before the instruction. A pop whose destination is the stack pointer itself loads the popped word into the stack pointer, and no increment follows.

Top module: `stack_op_unit`

## Requirements
- R1: A push (`opSel`=2'b00) writes `pushVal` (the value captured at `start`, even when it is a copy of the stack pointer) to address `spIn`-8. It ends with `spOut`=`spIn`-8, `spWe`=1, `pcOut`=`nextPc` and `status`=2'b00 (success).
- R2: A call (`opSel`=2'b10) writes `nextPc` to address `spIn`-8. It ends with `spOut`=`spIn`-8, `spWe`=1 and `pcOut`=`callTarget`.
- R3: When the address of a push or call is out of range, no memory access is made. The instruction ends with `status`=2'b01 (address error), `spOut`=`spIn` (the pointer is rolled back), `spWe`=0 and `popWe`=0.
- R4: A return (`opSel`=2'b11) reads the word at `spIn`. It ends with `pcOut` equal to that word, `spOut`=`spIn`+8 and `spWe`=1.
- R5: A pop (`opSel`=2'b01) reads the word at `spIn`. It ends with `popVal` equal to that word, `popWe`=1, `popDestOut`=`popDest`, `spOut`=`spIn`+8, `spWe`=1 and `pcOut`=`nextPc`.
- R6: A pop whose `popDest` equals the stack-pointer register number (4) ends with `spOut` equal to the popped word, `spWe`=0 and `popWe`=1, so no increment takes place.
- R7: When the address of a pop or return is out of range, no memory access is made. The instruction ends with `status`=2'b01, `spOut`=`spIn`, `spWe`=0 and `popWe`=0.
- R8: An address is valid when it lies in 0 to MEM_SIZE-8, taken as unsigned. MEM_SIZE-8 is therefore accepted and MEM_SIZE-7 faults. `memReq` is never raised for an invalid address.
- R9: After any address error, `pcOut` equals `curPc`, the address of the faulting instruction.
- R10: `done` is high for exactly one cycle, four clock edges after the edge that accepts `start`. `busy` is high from acceptance until `done`, and a `start` seen while `busy` is high is ignored.
- R11: After reset, `done`, `busy` and `memReq` are 0 and `status` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction when idle |
| opSel | input | 2 | 00 push, 01 pop, 10 call, 11 return |
| spIn | input | 64 | Stack pointer before the instruction |
| pushVal | input | 64 | Register value to push |
| nextPc | input | 64 | Address of the sequential next instruction |
| callTarget | input | 64 | Call destination |
| curPc | input | 64 | Address of this instruction |
| popDest | input | 4 | Destination register number of a pop |
| memReq | output | 1 | Memory access strobe |
| memWe | output | 1 | Access is a write |
| memAddr | output | 64 | Access address |
| memWdata | output | 64 | Write data |
| memRdata | input | 64 | Read data, valid in the access cycle |
| done | output | 1 | Result valid, one cycle |
| busy | output | 1 | Instruction in progress |
| status | output | 2 | 00 success, 01 address error |
| spOut | output | 64 | Final stack pointer |
| spWe | output | 1 | Write spOut to the stack pointer (with done) |
| pcOut | output | 64 | Next program counter |
| popVal | output | 64 | Popped word |
| popWe | output | 1 | Write popVal to popDestOut (with done) |
| popDestOut | output | 4 | Destination register of the pop |

## Verification
On every cycle, the assertions check that no access is issued outside the valid range and that only pushes and calls write. They also check the single-cycle `done` and its fixed latency, and that a faulting instruction restores the pointer, suppresses both register writes and reports its own PC. The pointer arithmetic on success for pushes and returns is asserted as well. The data path is shown only by the bench's scenarios: which word is stored, the popped value and the return target read back through memory, the pop into the stack pointer, the exact range boundary and a start that arrives while busy.

// File: rtl/stack_op_pkg.sv
package stack_op_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_CALL = 2'b10,
    OP_RET  = 2'b11
  } stackOp_e;

  typedef enum logic [1:0] {
    ST_OK   = 2'b00,
    ST_ADDR = 2'b01
  } stackStatus_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADJUST,
    S_ACCESS,
    S_COMMIT,
    S_DONE
  } fsmState_e;

  typedef struct packed {
    logic latch;
    logic calcAddr;
    logic memAccess;
    logic commit;
  } ctrlStrobes_t;
endpackage

// File: rtl/stack_op_ctrl.sv
module stack_op_ctrl
  import stack_op_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strobes,
  output logic         done,
  output logic         busy
);
  fsmState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:   if (start) stateNext = S_ADJUST;
      S_ADJUST: stateNext = S_ACCESS;
      S_ACCESS: stateNext = S_COMMIT;
      S_COMMIT: stateNext = S_DONE;
      S_DONE:   stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    strobes           = '0;
    strobes.latch     = (state == S_IDLE) && start;
    strobes.calcAddr  = (state == S_ADJUST);
    strobes.memAccess = (state == S_ACCESS);
    strobes.commit    = (state == S_COMMIT);
  end

  assign done = (state == S_DONE);
  assign busy = (state != S_IDLE);
endmodule

// File: rtl/stack_op_dp.sv
module stack_op_dp
  import stack_op_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int MEM_SIZE  = 256,
  parameter int REG_ID_W  = 4,
  parameter int SP_REG_ID = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [1:0]          opSel,
  input  logic [DATA_W-1:0]   spIn,
  input  logic [DATA_W-1:0]   pushVal,
  input  logic [DATA_W-1:0]   nextPc,
  input  logic [DATA_W-1:0]   callTarget,
  input  logic [DATA_W-1:0]   curPc,
  input  logic [REG_ID_W-1:0] popDest,
  output logic                memReq,
  output logic                memWe,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [1:0]          status,
  output logic [DATA_W-1:0]   spOut,
  output logic                spWeLvl,
  output logic [DATA_W-1:0]   pcOut,
  output logic [DATA_W-1:0]   popVal,
  output logic                popWeLvl,
  output logic [REG_ID_W-1:0] popDestOut
);
  localparam logic [DATA_W-1:0] STEP      = DATA_W'(DATA_W / 8);
  localparam logic [DATA_W-1:0] LAST_ADDR = DATA_W'(MEM_SIZE - DATA_W / 8);
  localparam logic [REG_ID_W-1:0] SP_ID   = REG_ID_W'(SP_REG_ID);

  stackOp_e            opR;
  logic [DATA_W-1:0]   spR, pushValR, nextPcR, targetR, curPcR;
  logic [REG_ID_W-1:0] destR;
  logic [DATA_W-1:0]   accAddr, addrNext, rdData;
  logic                accOk, isWrite;
  stackStatus_e        statusR;

  assign isWrite  = (opR == OP_PUSH) || (opR == OP_CALL);
  assign addrNext = isWrite ? (spR - STEP) : spR;

  // operand capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR      <= OP_PUSH;
      spR      <= '0;
      pushValR <= '0;
      nextPcR  <= '0;
      targetR  <= '0;
      curPcR   <= '0;
      destR    <= '0;
    end else if (strobes.latch) begin
      opR      <= stackOp_e'(opSel);
      spR      <= spIn;
      pushValR <= pushVal;
      nextPcR  <= nextPc;
      targetR  <= callTarget;
      curPcR   <= curPc;
      destR    <= popDest;
    end
  end

  // address adjust and range check
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accAddr <= '0;
      accOk   <= 1'b0;
    end else if (strobes.calcAddr) begin
      accAddr <= addrNext;
      accOk   <= (addrNext <= LAST_ADDR);
    end
  end

  // single memory access
  assign memReq   = strobes.memAccess && accOk;
  assign memWe    = memReq && isWrite;
  assign memAddr  = accAddr;
  assign memWdata = (opR == OP_PUSH) ? pushValR : nextPcR;

  always_ff @(posedge clk) begin
    if (!rstN)                    rdData <= '0;
    else if (memReq && !isWrite)  rdData <= memRdata;
  end

  // commit results
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusR    <= ST_OK;
      spOut      <= '0;
      spWeLvl    <= 1'b0;
      pcOut      <= '0;
      popVal     <= '0;
      popWeLvl   <= 1'b0;
      popDestOut <= '0;
    end else if (strobes.commit) begin
      popDestOut <= destR;
      popVal     <= '0;
      popWeLvl   <= 1'b0;
      if (!accOk) begin
        statusR <= ST_ADDR;
        spOut   <= spR;
        spWeLvl <= 1'b0;
        pcOut   <= curPcR;
      end else begin
        statusR <= ST_OK;
        unique case (opR)
          OP_PUSH: begin
            spOut   <= accAddr;
            spWeLvl <= 1'b1;
            pcOut   <= nextPcR;
          end
          OP_CALL: begin
            spOut   <= accAddr;
            spWeLvl <= 1'b1;
            pcOut   <= targetR;
          end
          OP_RET: begin
            spOut   <= spR + STEP;
            spWeLvl <= 1'b1;
            pcOut   <= rdData;
          end
          OP_POP: begin
            popVal   <= rdData;
            popWeLvl <= 1'b1;
            pcOut    <= nextPcR;
            if (destR == SP_ID) begin
              spOut   <= rdData;
              spWeLvl <= 1'b0;
            end else begin
              spOut   <= spR + STEP;
              spWeLvl <= 1'b1;
            end
          end
          default: begin
            spOut   <= spR;
            spWeLvl <= 1'b0;
            pcOut   <= curPcR;
          end
        endcase
      end
    end
  end

  assign status = statusR;
endmodule

// File: rtl/stack_op_unit.sv
module stack_op_unit
  import stack_op_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int MEM_SIZE  = 256,
  parameter int REG_ID_W  = 4,
  parameter int SP_REG_ID = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [1:0]          opSel,
  input  logic [DATA_W-1:0]   spIn,
  input  logic [DATA_W-1:0]   pushVal,
  input  logic [DATA_W-1:0]   nextPc,
  input  logic [DATA_W-1:0]   callTarget,
  input  logic [DATA_W-1:0]   curPc,
  input  logic [REG_ID_W-1:0] popDest,
  output logic                memReq,
  output logic                memWe,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  output logic                done,
  output logic                busy,
  output logic [1:0]          status,
  output logic [DATA_W-1:0]   spOut,
  output logic                spWe,
  output logic [DATA_W-1:0]   pcOut,
  output logic [DATA_W-1:0]   popVal,
  output logic                popWe,
  output logic [REG_ID_W-1:0] popDestOut
);
  ctrlStrobes_t strobes;
  logic         spWeLvl, popWeLvl;

  stack_op_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .done    (done),
    .busy    (busy)
  );

  stack_op_dp #(
    .DATA_W    (DATA_W),
    .MEM_SIZE  (MEM_SIZE),
    .REG_ID_W  (REG_ID_W),
    .SP_REG_ID (SP_REG_ID)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .opSel      (opSel),
    .spIn       (spIn),
    .pushVal    (pushVal),
    .nextPc     (nextPc),
    .callTarget (callTarget),
    .curPc      (curPc),
    .popDest    (popDest),
    .memReq     (memReq),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .status     (status),
    .spOut      (spOut),
    .spWeLvl    (spWeLvl),
    .pcOut      (pcOut),
    .popVal     (popVal),
    .popWeLvl   (popWeLvl),
    .popDestOut (popDestOut)
  );

  assign spWe  = done && spWeLvl;
  assign popWe = done && popWeLvl;
endmodule

// File: rtl/stack_op_checker.sv
module stack_op_checker #(
  parameter int DATA_W   = 64,
  parameter int MEM_SIZE = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [1:0]        opSel,
  input logic [DATA_W-1:0] spIn,
  input logic [DATA_W-1:0] curPc,
  input logic              memReq,
  input logic              memWe,
  input logic [DATA_W-1:0] memAddr,
  input logic              done,
  input logic              busy,
  input logic [1:0]        status,
  input logic [DATA_W-1:0] spOut,
  input logic              spWe,
  input logic [DATA_W-1:0] pcOut,
  input logic              popWe
);
  localparam logic [DATA_W-1:0] STEP      = DATA_W'(DATA_W / 8);
  localparam logic [DATA_W-1:0] LAST_ADDR = DATA_W'(MEM_SIZE - DATA_W / 8);

  logic              accept;
  logic [1:0]        capOp;
  logic [DATA_W-1:0] capSp, capPc;

  assign accept = rstN && start && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capOp <= 2'b00;
      capSp <= '0;
      capPc <= '0;
    end else if (accept) begin
      capOp <= opSel;
      capSp <= spIn;
      capPc <= curPc;
    end
  end

  assert_mem_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr <= LAST_ADDR));

  assert_write_kind_R2: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (capOp == 2'b00 || capOp == 2'b10));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(accept, 4) |-> done);

  assert_fault_restore_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && status == 2'b01) |-> (spOut == capSp && !spWe && !popWe));

  assert_fault_pc_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && status == 2'b01) |-> (pcOut == capPc));

  assert_push_sp_R1: assert property (@(posedge clk) disable iff (!rstN)
    (done && status == 2'b00 && capOp == 2'b00) |-> (spOut == capSp - STEP && spWe));

  assert_ret_sp_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && status == 2'b00 && capOp == 2'b11) |-> (spOut == capSp + STEP && spWe));
endmodule

bind stack_op_unit stack_op_checker #(
  .DATA_W   (DATA_W),
  .MEM_SIZE (MEM_SIZE)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .opSel   (opSel),
  .spIn    (spIn),
  .curPc   (curPc),
  .memReq  (memReq),
  .memWe   (memWe),
  .memAddr (memAddr),
  .done    (done),
  .busy    (busy),
  .status  (status),
  .spOut   (spOut),
  .spWe    (spWe),
  .pcOut   (pcOut),
  .popWe   (popWe)
);

// File: tb/stack_op_unit_tb.sv
module stack_op_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_SIZE   = 256;
  localparam int WORDS      = MEM_SIZE / 8;
  localparam int IDX_W      = $clog2(WORDS);
  localparam int LIMIT      = 5000;

  typedef struct packed {
    logic [63:0] sp;
    logic        spWe;
    logic [63:0] popVal;
    logic        popWe;
    logic [3:0]  dest;
    logic [63:0] pc;
    logic [1:0]  status;
    logic [3:0]  accesses;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [63:0] spIn = '0, pushVal = '0, nextPc = '0, callTarget = '0, curPc = '0;
  logic [3:0]  popDest = '0;
  logic        memReq, memWe;
  logic [63:0] memAddr, memWdata, memRdata;
  logic        done, busy, spWe, popWe;
  logic [1:0]  status;
  logic [63:0] spOut, pcOut, popVal;
  logic [3:0]  popDestOut;

  logic [63:0] memWords [WORDS];

  int    nChecks = 0, nFails = 0, cyc = 0, acceptCyc = 0, accCount = 0;
  bit    finished = 1'b0;
  exp_t  expQ[$];
  string tagQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  stack_op_unit #(.MEM_SIZE(MEM_SIZE)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .spIn(spIn),
    .pushVal(pushVal), .nextPc(nextPc), .callTarget(callTarget), .curPc(curPc),
    .popDest(popDest), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .done(done), .busy(busy),
    .status(status), .spOut(spOut), .spWe(spWe), .pcOut(pcOut),
    .popVal(popVal), .popWe(popWe), .popDestOut(popDestOut)
  );

  assign memRdata = memWords[memAddr[IDX_W+2:3]];

  always @(posedge clk) begin
    if (memReq && memWe) memWords[memAddr[IDX_W+2:3]] <= memWdata;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // posedge monitor: cycle count, acceptance and access counting
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rstN && start && !busy) begin
      acceptCyc = cyc;
      accCount  = 0;
    end else if (memReq) begin
      accCount = accCount + 1;
    end
    if (cyc > LIMIT) begin
      nChecks++;
      nFails++;
      $display("FAIL R10 watchdog: actual %0d expected <= %0d cycles", cyc, LIMIT);
      finishRun();
    end
  end

  // negedge monitor: scoreboard compare on done
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t  e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(cyc - acceptCyc == 3, {t, " R10"}, "latency", 64'(cyc - acceptCyc), 64'd3);
        check(status == e.status, t, "status", 64'(status), 64'(e.status));
        check(spOut == e.sp, t, "spOut", spOut, e.sp);
        check(spWe == e.spWe, t, "spWe", 64'(spWe), 64'(e.spWe));
        check(pcOut == e.pc, t, "pcOut", pcOut, e.pc);
        check(popWe == e.popWe, t, "popWe", 64'(popWe), 64'(e.popWe));
        check(accCount == int'(e.accesses), t, "memory accesses", 64'(accCount), 64'(e.accesses));
        if (e.popWe) begin
          check(popVal == e.popVal, t, "popVal", popVal, e.popVal);
          check(popDestOut == e.dest, t, "popDestOut", 64'(popDestOut), 64'(e.dest));
        end
      end
    end
  end

  task automatic runOp(input logic [1:0] op, input logic [63:0] sp, input logic [63:0] pv,
                       input logic [63:0] np, input logic [63:0] tgt, input logic [63:0] pc,
                       input logic [3:0] dst, input exp_t e, input string tag,
                       input bit poke);
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    opSel = op; spIn = sp; pushVal = pv; nextPc = np;
    callTarget = tgt; curPc = pc; popDest = dst; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      opSel = 2'b01; spIn = 64'h10; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  function automatic exp_t mk(input logic [63:0] sp, input logic spw, input logic [63:0] pv,
                              input logic pw, input logic [3:0] d, input logic [63:0] pc,
                              input logic [1:0] st, input logic [3:0] acc);
    exp_t e;
    e.sp = sp; e.spWe = spw; e.popVal = pv; e.popWe = pw; e.dest = d;
    e.pc = pc; e.status = st; e.accesses = acc;
    return e;
  endfunction

  initial begin
    for (int i = 0; i < WORDS; i++) memWords[i] = 64'(i) * 64'h0101;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(done == 1'b0, "R11", "done", 64'(done), 64'd0);
    check(busy == 1'b0, "R11", "busy", 64'(busy), 64'd0);
    check(memReq == 1'b0, "R11", "memReq", 64'(memReq), 64'd0);
    check(status == 2'b00, "R11", "status", 64'(status), 64'd0);

    // R1 push
    runOp(2'b00, 64'h80, 64'hA5A5_0000_1234_5678, 64'h402, 64'h0, 64'h400, 4'd0,
          mk(64'h78, 1, 0, 0, 0, 64'h402, 2'b00, 1), "R1", 0);
    check(memWords[15] == 64'hA5A5_0000_1234_5678, "R1", "stored word", memWords[15], 64'hA5A5_0000_1234_5678);

    // R5 pop of that word
    runOp(2'b01, 64'h78, 64'h0, 64'h502, 64'h0, 64'h500, 4'd3,
          mk(64'h80, 1, 64'hA5A5_0000_1234_5678, 1, 4'd3, 64'h502, 2'b00, 1), "R5", 0);

    // R2 call at top boundary (R8: MEM_SIZE-8 valid)
    runOp(2'b10, 64'h100, 64'h0, 64'h609, 64'h7000, 64'h600, 4'd0,
          mk(64'hF8, 1, 0, 0, 0, 64'h7000, 2'b00, 1), "R2 R8", 0);
    check(memWords[31] == 64'h609, "R2", "return address stored", memWords[31], 64'h609);

    // R4 return reads it back
    runOp(2'b11, 64'hF8, 64'h0, 64'h7001, 64'h0, 64'h7000, 4'd0,
          mk(64'h100, 1, 0, 0, 0, 64'h609, 2'b00, 1), "R4", 0);

    // R3 R9 push fault at zero pointer
    runOp(2'b00, 64'h0, 64'h1111, 64'h802, 64'h0, 64'h800, 4'd0,
          mk(64'h0, 0, 0, 0, 0, 64'h800, 2'b01, 0), "R3 R9", 0);
    // R3 call fault
    runOp(2'b10, 64'h4, 64'h0, 64'h909, 64'h3000, 64'h900, 4'd0,
          mk(64'h4, 0, 0, 0, 0, 64'h900, 2'b01, 0), "R3", 0);
    // R7 R8 pop fault at MEM_SIZE-7
    runOp(2'b01, 64'hF9, 64'h0, 64'hA02, 64'h0, 64'hA00, 4'd2,
          mk(64'hF9, 0, 0, 0, 0, 64'hA00, 2'b01, 0), "R7 R8", 0);
    // R7 return fault far out
    runOp(2'b11, 64'h200, 64'h0, 64'hB01, 64'h0, 64'hB00, 4'd0,
          mk(64'h200, 0, 0, 0, 0, 64'hB00, 2'b01, 0), "R7 R9", 0);

    // R6 pop into the stack pointer
    runOp(2'b01, 64'h78, 64'h0, 64'hC02, 64'h0, 64'hC00, 4'd4,
          mk(64'hA5A5_0000_1234_5678, 0, 64'hA5A5_0000_1234_5678, 1, 4'd4, 64'hC02, 2'b00, 1), "R6", 0);

    // R1 push of the stack pointer itself stores the old value
    runOp(2'b00, 64'h50, 64'h50, 64'hD02, 64'h0, 64'hD00, 4'd0,
          mk(64'h48, 1, 0, 0, 0, 64'hD02, 2'b00, 1), "R1", 0);
    check(memWords[9] == 64'h50, "R1", "old pointer stored", memWords[9], 64'h50);

    // R10 start while busy ignored
    runOp(2'b00, 64'h40, 64'h77, 64'hE02, 64'h0, 64'hE00, 4'd0,
          mk(64'h38, 1, 0, 0, 0, 64'hE02, 2'b00, 1), "R10", 1);
    check(expQ.size() == 0, "R10", "pending results", 64'(expQ.size()), 64'd0);
    check(memWords[7] == 64'h77, "R10", "first op stored", memWords[7], 64'h77);

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule